// File: doc/BRIEF.md
# Sticky Pending Interrupt Aggregator

This block collects 24 interrupt inputs and folds them into one request line for a parent interrupt controller. Each input has a pending bit that stays set after it is captured and an enable bit. Software reads an identity word, which is the pending bits ANDed with the enable bits, and scans it to find the sources that need service. It then writes ones to the pending register to acknowledge them.

Two trigger-mode registers choose how each input is captured. When a source has a 0 in both registers it is level-sensitive. A 1 in the rising register captures rising edges, and a 1 in the falling register captures falling edges. Software can write the enable register directly. It can also use a write-one-to-set alias and a write-one-to-clear alias, so one bit can change without a read-modify-write. The register port is a plain 32-bit bus. Writes take effect on the clock edge where the write strobe is high, and read data follows the address combinationally.

Top module: `irq_sticky_aggr`

## Requirements
- R1: After reset every register reads zero and `irq_out` is low.
- R2: The pending register sits at offset 0x10. Writing a 1 to bit i clears pending bit i, and bits written with 0 keep their value. A pending bit never clears by any other means.
- R3: A source with a 0 in both trigger registers is level-sensitive. Its pending bit is set on every cycle its registered input is high. A clear written in the same cycle loses to the set. An input that is high before clock edge k shows as pending after edge k+1.
- R4: Bit i of the rising-trigger register (0x5c) makes source i capture a low-to-high change. Bit i of the falling-trigger register (0x60) makes it capture a high-to-low change. Setting both captures either change. An edge-mode source that stays at a constant level sets nothing.
- R5: The enable register at 0x18 can be read and written directly.
- R6: Writing ones at 0x20 sets the matching enable bits, and writing ones at 0x1c clears them. Zero bits leave the enables unchanged. Both alias addresses read as zero.
- R7: The identity register for destination 0 is at 0x38 and reads pending AND enable. The identity register for destination 1 (0x3c) reads zero, because no source is routed to it.
- R8: `irq_out` is the OR of the 24 identity bits, registered once, so it lags the identity word by one cycle.
- R9: Bits 31..24 always read zero, and writes to them are ignored. Reads of unmapped or misaligned offsets return zero.
- R10: With all inputs low, writing all-ones to 0x10 and then zero to 0x18 leaves no bit pending, no bit enabled and `irq_out` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_in | input | 24 | Interrupt source inputs |
| irq_out | output | 1 | Combined request to the parent controller |

## Verification
The bench targets these corner cases:
- **Acknowledging a level source while its input is still high.** A design that lets the clear win would drop a live request for one cycle, and the bench would see a zero in the identity word.
- **Edge-mode sources held at a constant level.** A design that treats edge mode as level would re-set the bit after it is acknowledged.
- **The falling trigger.** A design that decodes the falling trigger wrongly would miss high-to-low captures.
- **The set and clear aliases with sparse masks.** These expose aliases that overwrite the whole enable register instead of changing only the masked bits.
- **Upper-bit writes and off-map or misaligned reads.** These catch decoding that aliases addresses or stores bits 31..24.

Random traffic then checks the registered `irq_out` lag against a bench model.

// File: rtl/irqagg_pkg.sv
// Shared constants and the register decoder for the sticky interrupt
// aggregator. It assumes byte addresses that are word aligned and an
// 8-bit offset space.
package irqagg_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_PEND      = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_ENA       = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_ENA_CLR   = 8'h1c;
    localparam logic [ADDR_W-1:0] OFS_ENA_SET   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_IDENT     = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_TRIG_RISE = 8'h5c;
    localparam logic [ADDR_W-1:0] OFS_TRIG_FALL = 8'h60;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_ENA,
        SEL_ENA_CLR,
        SEL_ENA_SET,
        SEL_IDENT,
        SEL_TRIG_RISE,
        SEL_TRIG_FALL
    } regsel_e;

    // Map a byte offset to a register selector; ndest sets how many identity words exist.
    function automatic regsel_e decode_sel(input logic [ADDR_W-1:0] addr,
                                           input int unsigned ndest);
        regsel_e sel;
        int      a;
        int      id_lo;
        a     = int'(addr);
        id_lo = int'(OFS_IDENT);
        sel   = SEL_NONE;
        if (addr[1:0] == 2'b00) begin
            case (addr)
                OFS_PEND:      sel = SEL_PEND;
                OFS_ENA:       sel = SEL_ENA;
                OFS_ENA_CLR:   sel = SEL_ENA_CLR;
                OFS_ENA_SET:   sel = SEL_ENA_SET;
                OFS_TRIG_RISE: sel = SEL_TRIG_RISE;
                OFS_TRIG_FALL: sel = SEL_TRIG_FALL;
                default: begin
                    if (a >= id_lo && a < id_lo + 4 * int'(ndest))
                        sel = SEL_IDENT;
                end
            endcase
        end
        return sel;
    endfunction

endpackage

// File: rtl/irqagg_ctrl.sv
// Holds the enable and trigger-mode registers and turns pending-register
// writes into a clear mask. It assumes that the upper write-data bits have
// already been dropped by the caller.
module irqagg_ctrl
    import irqagg_pkg::*;
#(
    parameter int NUM_SRC = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  regsel_e            wr_sel,
    input  logic [NUM_SRC-1:0] wr_bits,
    output logic [NUM_SRC-1:0] ena_q,
    output logic [NUM_SRC-1:0] rise_q,
    output logic [NUM_SRC-1:0] fall_q,
    output logic [NUM_SRC-1:0] pend_clr
);

    // Enable register: direct write, set alias and clear alias.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_ENA:     ena_q <= wr_bits;
                SEL_ENA_SET: ena_q <= ena_q | wr_bits;
                SEL_ENA_CLR: ena_q <= ena_q & ~wr_bits;
                default:     ena_q <= ena_q;
            endcase
        end
    end

    // Trigger-mode registers: one for rising capture, one for falling capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_TRIG_RISE) rise_q <= wr_bits;
            if (wr_sel == SEL_TRIG_FALL) fall_q <= wr_bits;
        end
    end

    // Write-one-to-clear mask for the pending bits.
    always_comb begin
        pend_clr = (wr_en && wr_sel == SEL_PEND) ? wr_bits : '0;
    end

endmodule

// File: rtl/irqagg_capture.sv
// Registers the raw inputs once, detects edges against the previous sample
// and keeps one sticky pending bit per source. It assumes the inputs are
// already synchronous to clk. A capture in a cycle beats a clear in that cycle.
module irqagg_capture #(
    parameter int NUM_SRC = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] rise_en,
    input  logic [NUM_SRC-1:0] fall_en,
    input  logic [NUM_SRC-1:0] pend_clr,
    output logic [NUM_SRC-1:0] pend_q
);

    logic [NUM_SRC-1:0] src_s;
    logic [NUM_SRC-1:0] src_d;

    // Sample the inputs and keep the previous sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_s <= '0;
            src_d <= '0;
        end else begin
            src_s <= src_in;
            src_d <= src_s;
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic lvl_mode;
        logic hit;
        logic bit_q;

        // Choose level or edge capture for this source.
        always_comb begin
            lvl_mode = !(rise_en[i] || fall_en[i]);
            if (lvl_mode)
                hit = src_s[i];
            else
                hit = (rise_en[i] &&  src_s[i] && !src_d[i]) ||
                      (fall_en[i] && !src_s[i] &&  src_d[i]);
        end

        // Sticky bit: a capture sets it, a write-one clears it, and the capture wins.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (hit)
                bit_q <= 1'b1;
            else if (pend_clr[i])
                bit_q <= 1'b0;
        end

        assign pend_q[i] = bit_q;
    end

endmodule

// File: rtl/irqagg_output.sv
// Forms the destination-0 identity word and the registered request line.
// It assumes only destination 0 has sources routed to it.
module irqagg_output #(
    parameter int NUM_SRC = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_q,
    input  logic [NUM_SRC-1:0] ena_q,
    output logic [NUM_SRC-1:0] ident0,
    output logic               irq_out
);

    // Sources that are pending and enabled.
    always_comb begin
        ident0 = pend_q & ena_q;
    end

    // Registered OR of the identity word toward the parent controller.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_out <= 1'b0;
        else
            irq_out <= |ident0;
    end

endmodule

// File: rtl/irq_sticky_aggr.sv
// Top level of the sticky interrupt aggregator. It decodes the register
// bus, instantiates the control, capture and output stages and returns
// zero-extended read data. It assumes NUM_SRC <= DATA_W.
module irq_sticky_aggr
    import irqagg_pkg::*;
#(
    parameter int NUM_SRC  = 24,
    parameter int NUM_DEST = 2,
    parameter int DATA_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_in,
    output logic               irq_out
);

    regsel_e            sel;
    logic [NUM_SRC-1:0] wr_bits;
    logic [NUM_SRC-1:0] ena_q;
    logic [NUM_SRC-1:0] rise_q;
    logic [NUM_SRC-1:0] fall_q;
    logic [NUM_SRC-1:0] pend_clr;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] ident0;
    logic [NUM_SRC-1:0] rd_bits;

    // Decode the offset and drop the write-data bits above the source count.
    always_comb begin
        sel     = decode_sel(bus_addr, NUM_DEST);
        wr_bits = bus_wdata[NUM_SRC-1:0];
    end

    if (NUM_SRC < DATA_W) begin : g_hi
        logic unused_wr_hi;
        assign unused_wr_hi = ^bus_wdata[DATA_W-1:NUM_SRC];
    end

    irqagg_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .wr_sel   (sel),
        .wr_bits  (wr_bits),
        .ena_q    (ena_q),
        .rise_q   (rise_q),
        .fall_q   (fall_q),
        .pend_clr (pend_clr)
    );

    irqagg_capture #(.NUM_SRC(NUM_SRC)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .rise_en  (rise_q),
        .fall_en  (fall_q),
        .pend_clr (pend_clr),
        .pend_q   (pend_q)
    );

    irqagg_output #(.NUM_SRC(NUM_SRC)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_q  (pend_q),
        .ena_q   (ena_q),
        .ident0  (ident0),
        .irq_out (irq_out)
    );

    // Read multiplexer: aliases, the other identity words and unmapped offsets return zero.
    always_comb begin
        case (sel)
            SEL_PEND:      rd_bits = pend_q;
            SEL_ENA:       rd_bits = ena_q;
            SEL_IDENT:     rd_bits = (bus_addr == OFS_IDENT) ? ident0 : '0;
            SEL_TRIG_RISE: rd_bits = rise_q;
            SEL_TRIG_FALL: rd_bits = fall_q;
            default:       rd_bits = '0;
        endcase
        bus_rdata = '0;
        bus_rdata[NUM_SRC-1:0] = rd_bits;
    end

endmodule

// File: rtl/irqagg_checker.sv
// Property checker for irq_sticky_aggr, attached by bind. It watches the
// bus, the request line and the pending and enable state.
module irqagg_checker
    import irqagg_pkg::*;
#(
    parameter int NUM_SRC = 24,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [NUM_SRC-1:0] wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               irq_out,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] ena
);

    logic               wr_pend;
    logic               wr_set;
    logic               wr_clr;
    logic [NUM_SRC-1:0] clr_mask;

    // Decode the write strobes that the properties refer to.
    always_comb begin
        wr_pend  = bus_wr && bus_addr == OFS_PEND;
        wr_set   = bus_wr && bus_addr == OFS_ENA_SET;
        wr_clr   = bus_wr && bus_addr == OFS_ENA_CLR;
        clr_mask = wr_pend ? wdata : '0;
    end

    AST_PEND_CLEARS_ONLY_ON_W1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend) & ~pend) & ~$past(clr_mask)) == '0)); // R2

    AST_ENA_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((ena & $past(wdata)) == $past(wdata))); // R6

    AST_ENA_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((ena & $past(wdata)) == '0)); // R6

    AST_IDENT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_IDENT) |-> (bus_rdata[NUM_SRC-1:0] == (pend & ena))); // R7

    AST_IRQ_LAGS_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(|(pend & ena)))); // R8

    if (NUM_SRC < DATA_W) begin : g_hi
        AST_UPPER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rdata[DATA_W-1:NUM_SRC] == '0); // R9
    end

endmodule

bind irq_sticky_aggr irqagg_checker #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wdata     (bus_wdata[NUM_SRC-1:0]),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .pend      (pend_q),
    .ena       (ena_q)
);

// File: tb/sim_irq_sticky_aggr.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases followed by seeded random
// register traffic, checked against a cycle model built from the requirements.
module sim_irq_sticky_aggr;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [23:0] src_in;
    logic        irq_out;

    int nchk  = 0;
    int nfail = 0;

    // Model state
    logic [23:0] m_q, m_prev, m_pend, m_en, m_rise, m_fall;
    logic        m_irq;

    always #2.5 clk = ~clk;

    irq_sticky_aggr u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_in    (src_in),
        .irq_out   (irq_out)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h10:   return {8'h00, m_pend};
            8'h18:   return {8'h00, m_en};
            8'h38:   return {8'h00, m_pend & m_en};
            8'h5c:   return {8'h00, m_rise};
            8'h60:   return {8'h00, m_fall};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one cycle from just after a falling edge; advance the model at the rising edge.
    task automatic tick(input logic wr, input logic [7:0] a, input logic [31:0] d, input logic [23:0] s);
        logic [23:0] set_v;
        logic [23:0] clr_v;
        bus_wr = wr; bus_addr = a; bus_wdata = d; src_in = s;
        @(posedge clk);
        set_v = (~m_rise & ~m_fall & m_q) | (m_rise & m_q & ~m_prev) | (m_fall & ~m_q & m_prev);
        clr_v = (wr && a == 8'h10) ? d[23:0] : 24'h0;
        m_irq  = |(m_pend & m_en);
        m_pend = (m_pend & ~clr_v) | set_v;
        if (wr && a == 8'h18) m_en = d[23:0];
        if (wr && a == 8'h20) m_en = m_en | d[23:0];
        if (wr && a == 8'h1c) m_en = m_en & ~d[23:0];
        if (wr && a == 8'h5c) m_rise = d[23:0];
        if (wr && a == 8'h60) m_fall = d[23:0];
        m_prev = m_q;
        m_q    = s;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        tick(1'b0, a, 32'h0, src_in);
        check(tag, bus_rdata, exp_read(a));
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        tick(1'b1, a, d, src_in);
    endtask

    task automatic hold(input logic [23:0] s, input int n);
        for (int k = 0; k < n; k++) tick(1'b0, 8'h00, 32'h0, s);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 5);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] alist [9];
        logic [23:0] s;
        alist = '{8'h10, 8'h18, 8'h1c, 8'h20, 8'h38, 8'h3c, 8'h5c, 8'h60, 8'h44};
        void'($urandom(32'd1234));
        m_q = '0; m_prev = '0; m_pend = '0; m_en = '0; m_rise = '0; m_fall = '0; m_irq = 1'b0;
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; src_in = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd("R1 pend", 8'h10); rd("R1 ena", 8'h18); rd("R1 ident", 8'h38);
        rd("R1 rise", 8'h5c); rd("R1 fall", 8'h60);
        check("R1 irq", {31'h0, irq_out}, 32'h0);

        // R10: start-up sequence
        wr(8'h10, 32'hffff_ffff); wr(8'h18, 32'h0);
        rd("R10 pend", 8'h10); rd("R10 ena", 8'h18);
        check("R10 irq", {31'h0, irq_out}, 32'h0);

        // R3: level source, latency and set beating clear
        tick(1'b0, 8'h10, 32'h0, 24'h000008);
        check("R3 not yet", bus_rdata, 32'h0);
        rd("R3 pend", 8'h10);
        check("R3 bit3", bus_rdata, 32'h0000_0008);
        wr(8'h20, 32'h0000_0008);
        rd("R7 ident", 8'h38);
        check("R8 irq high", {31'h0, irq_out}, 32'h1);
        wr(8'h10, 32'h0000_0008);
        rd("R3 clear loses", 8'h10);
        check("R3 still set", bus_rdata, 32'h0000_0008);
        hold(24'h0, 3);
        wr(8'h10, 32'h0000_0008);
        rd("R2 cleared", 8'h10);
        check("R2 bit3 zero", bus_rdata, 32'h0);
        rd("R8 irq low", 8'h38);
        check("R8 irq low", {31'h0, irq_out}, 32'h0);

        // R4: rising-edge capture and no re-capture while held
        wr(8'h5c, 32'h0000_0020);
        hold(24'h000020, 3);
        rd("R4 rise", 8'h10);
        check("R4 rise bit5", bus_rdata, 32'h0000_0020);
        wr(8'h10, 32'h0000_0020);
        hold(24'h000020, 3);
        rd("R4 held level", 8'h10);
        check("R4 no recapture", bus_rdata, 32'h0);
        hold(24'h0, 3);
        rd("R4 fall ignored", 8'h10);
        wr(8'h60, 32'h0000_0020);
        hold(24'h000020, 3);
        wr(8'h10, 32'h0000_0020);
        hold(24'h0, 3);
        rd("R4 fall captured", 8'h10);
        check("R4 fall bit5", bus_rdata, 32'h0000_0020);
        wr(8'h10, 32'h0000_0020);

        // R5 and R6: direct write and aliases
        wr(8'h18, 32'h00a5_0f0f);
        rd("R5 ena", 8'h18);
        check("R5 value", bus_rdata, 32'h00a5_0f0f);
        wr(8'h20, 32'h0010_0001);
        rd("R6 set", 8'h18);
        wr(8'h1c, 32'h0080_0100);
        rd("R6 clr", 8'h18);
        check("R6 value", bus_rdata, 32'h0035_0e0f);
        rd("R6 set alias reads 0", 8'h20);
        rd("R6 clr alias reads 0", 8'h1c);

        // R9 and R7: upper bits, unmapped, misaligned, second destination
        wr(8'h18, 32'hffff_ffff);
        rd("R9 upper", 8'h18);
        check("R9 value", bus_rdata, 32'h00ff_ffff);
        rd("R9 unmapped", 8'h44);
        tick(1'b0, 8'h11, 32'h0, src_in);
        check("R9 misaligned", bus_rdata, 32'h0);
        rd("R7 dest1", 8'h3c);
        wr(8'h18, 32'h0);

        // Seeded random traffic
        s = '0;
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a;
            a = alist[$urandom_range(0, 8)];
            s = s ^ ($urandom() & $urandom() & $urandom());
            tick(($urandom() & 1) == 1, a, $urandom(), s[23:0]);
            check("RND R2-model read", bus_rdata, exp_read(a));
            check("RND R8 irq", {31'h0, irq_out}, {31'h0, m_irq});
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule